// File: doc/BRIEF.md
# Halt/Resume Group Cross-Trigger Unit

This unit ties the run-control events of a set of harts and of up to sixteen external trigger lines together through programmable group membership. Every hart and every trigger line holds two group numbers: one for halting and one for resuming. When a hart halts, or a trigger line that can sense fires, all other harts sharing that nonzero halt group receive a one-cycle halt request tagged with the group-halt cause code. Resume events spread the same way through resume groups. Resume requests are held back until the abstract command engine reports idle.

Group membership is written through a simple configuration port. Group 0 means "not grouped": events of its members are never spread. Trigger lines have fixed direction classes by index. Lines 0 to 7 both sense and drive. Lines 8 to 11 only sense. Lines 12 to 15 only drive. Hart events are taken from the rising edges of each hart's halted and running status inputs.

Top module: `xtg_crosstrig`

## Requirements
- R1: While `rst_n` is low, every output is 0 and every hart and trigger returns to halt group 0 and resume group 0. After reset, events in any group are not spread until membership is written again.
- R2: A configuration write stores `cfg_group` as the halt group (`cfg_resume`=0) or resume group (`cfg_resume`=1) of hart `cfg_index` (`cfg_trig`=0) or trigger line `cfg_index` (`cfg_trig`=1). A group value of NGROUPS or more is stored as 0.
- R3: An event of a member of group 0 produces no request and no trigger pulse.
- R4: A rising edge of `hart_halted[i]` in nonzero halt group g makes `grp_halt_req` pulse for one cycle, on the next cycle. The pulse goes to every hart in g whose `hart_halted` is 0 at that edge, which includes harts that are resuming. `halt_cause` reads 6 in that cycle and 0 whenever no halt request is issued.
- R5: A hart halt event in nonzero halt group g, or a hart resume event in nonzero resume group g, pulses `trig_out` on the next cycle. The pulse goes to every drive-capable trigger line that is a member of g.
- R6: A rising edge on a sense-capable `trig_in` line in nonzero halt group g requests a halt of every non-halted hart in g on the next cycle. It causes no `trig_out` pulse.
- R7: A rising edge of `hart_running[i]` in nonzero resume group g makes `grp_resume_req` pulse for one cycle. The pulse goes to every hart in g whose `hart_halted` is 1. It comes one cycle after the first clock edge, at or after the event, at which `abs_busy` is 0. A hart that is halting (halted and running both 0) is not resumed.
- R8: A rising edge on a sense-capable `trig_in` line in nonzero resume group g resumes the halted harts of g under the same busy rule as R7.
- R9: Trigger lines 12 to 15 are never sensed, and lines 8 to 11 are never driven.
- R10: A configuration write never by itself produces a halt request, a resume request or a trigger pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Debug module reset, active low, asynchronous |
| cfg_we | input | 1 | Membership write strobe |
| cfg_trig | input | 1 | 1 selects a trigger line, 0 a hart |
| cfg_resume | input | 1 | 1 writes the resume group, 0 the halt group |
| cfg_index | input | IW | Hart or trigger index |
| cfg_group | input | FW | Group number to store (clamped) |
| hart_halted | input | NHARTS | Per-hart halted status |
| hart_running | input | NHARTS | Per-hart running status |
| abs_busy | input | 1 | Abstract command in progress |
| trig_in | input | NTRIG | External trigger inputs |
| grp_halt_req | output | NHARTS | Group halt request pulses |
| grp_resume_req | output | NHARTS | Group resume request pulses |
| halt_cause | output | 3 | Cause code for the issued halt requests |
| trig_out | output | NTRIG | External trigger output pulses |

## Verification
The assertions take for granted that each status input reflects the hart's real state on the edge where a request is issued. They also assume that `abs_busy` is a level the engine holds, not a glitch. In the directed scenes the stimulus changes every input only on the falling clock edge, and a hart is never shown as both halted and running. The random phase keeps the same discipline and gives `abs_busy` runs of several cycles. This lets the deferred resume path stay pending and then drain.

// File: rtl/xtg_pkg.sv
package xtg_pkg;
  localparam logic [2:0] CAUSE_GROUP = 3'd6;

  function automatic logic trig_can_sense(input int unsigned k);
    return k < 12;
  endfunction

  function automatic logic trig_can_drive(input int unsigned k);
    return (k < 8) || ((k >= 12) && (k < 16));
  endfunction
endpackage

// File: rtl/xtg_edge.sv
module xtg_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/xtg_cfg.sv
module xtg_cfg #(
  parameter int NHARTS  = 4,
  parameter int NTRIG   = 16,
  parameter int NGROUPS = 4,
  parameter int GW      = 2,
  parameter int IW      = 4,
  parameter int FW      = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic                        is_trig,
  input  logic                        is_resume,
  input  logic [IW-1:0]               idx,
  input  logic [FW-1:0]               grp,
  output logic [NHARTS-1:0][GW-1:0]   hart_hg,
  output logic [NHARTS-1:0][GW-1:0]   hart_rg,
  output logic [NTRIG-1:0][GW-1:0]    trig_hg,
  output logic [NTRIG-1:0][GW-1:0]    trig_rg
);
  function automatic logic [GW-1:0] clamp_grp(input logic [FW-1:0] v);
    if (int'(v) >= NGROUPS) return '0;
    return GW'(v);
  endfunction

  logic [GW-1:0] wval;
  assign wval = clamp_grp(grp);

  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hart_hg[h] <= '0;
        hart_rg[h] <= '0;
      end else if (we && !is_trig && (int'(idx) == h)) begin
        if (is_resume) hart_rg[h] <= wval;
        else           hart_hg[h] <= wval;
      end
    end
  end

  for (genvar k = 0; k < NTRIG; k++) begin : g_trig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trig_hg[k] <= '0;
        trig_rg[k] <= '0;
      end else if (we && is_trig && (int'(idx) == k)) begin
        if (is_resume) trig_rg[k] <= wval;
        else           trig_hg[k] <= wval;
      end
    end
  end
endmodule

// File: rtl/xtg_resume_hold.sv
module xtg_resume_hold #(
  parameter int NGROUPS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NGROUPS-1:0] hit,
  input  logic               busy,
  output logic [NGROUPS-1:0] fire
);
  logic [NGROUPS-1:0] pend_q;
  logic [NGROUPS-1:0] want;

  assign want = pend_q | hit;
  assign fire = busy ? '0 : want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= busy ? want : '0;
  end
endmodule

// File: rtl/xtg_crosstrig.sv
module xtg_crosstrig #(
  parameter int NHARTS  = 4,
  parameter int NTRIG   = 16,
  parameter int NGROUPS = 4,
  parameter int FW      = 3,
  parameter int GW      = (NGROUPS > 1) ? $clog2(NGROUPS) : 1,
  parameter int IW      = $clog2((NTRIG > NHARTS) ? NTRIG : NHARTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_trig,
  input  logic              cfg_resume,
  input  logic [IW-1:0]     cfg_index,
  input  logic [FW-1:0]     cfg_group,
  input  logic [NHARTS-1:0] hart_halted,
  input  logic [NHARTS-1:0] hart_running,
  input  logic              abs_busy,
  input  logic [NTRIG-1:0]  trig_in,
  output logic [NHARTS-1:0] grp_halt_req,
  output logic [NHARTS-1:0] grp_resume_req,
  output logic [2:0]        halt_cause,
  output logic [NTRIG-1:0]  trig_out
);
  import xtg_pkg::*;

  logic [NHARTS-1:0][GW-1:0] hart_hg, hart_rg;
  logic [NTRIG-1:0][GW-1:0]  trig_hg, trig_rg;
  logic [NTRIG-1:0]          sense_mask, drive_mask, trig_sensed;
  logic [NHARTS-1:0]         halt_ev, resume_ev;
  logic [NTRIG-1:0]          trig_ev;
  logic [NGROUPS-1:0]        hg_hart_hit, hg_trig_hit, rg_hart_hit, rg_trig_hit;
  logic [NGROUPS-1:0]        rg_fire;
  logic [NHARTS-1:0]         halt_next, resume_next;
  logic [NTRIG-1:0]          tout_next;

  for (genvar k = 0; k < NTRIG; k++) begin : g_cls
    assign sense_mask[k] = trig_can_sense(k);
    assign drive_mask[k] = trig_can_drive(k);
  end
  assign trig_sensed = trig_in & sense_mask;

  xtg_cfg #(.NHARTS(NHARTS), .NTRIG(NTRIG), .NGROUPS(NGROUPS), .GW(GW), .IW(IW), .FW(FW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .is_trig(cfg_trig), .is_resume(cfg_resume),
    .idx(cfg_index), .grp(cfg_group),
    .hart_hg(hart_hg), .hart_rg(hart_rg), .trig_hg(trig_hg), .trig_rg(trig_rg)
  );

  xtg_edge #(.W(NHARTS)) u_halt_edge (.clk(clk), .rst_n(rst_n), .sig(hart_halted),  .rise(halt_ev));
  xtg_edge #(.W(NHARTS)) u_run_edge  (.clk(clk), .rst_n(rst_n), .sig(hart_running), .rise(resume_ev));
  xtg_edge #(.W(NTRIG))  u_trig_edge (.clk(clk), .rst_n(rst_n), .sig(trig_sensed),  .rise(trig_ev));

  always_comb begin
    hg_hart_hit = '0;
    rg_hart_hit = '0;
    hg_trig_hit = '0;
    rg_trig_hit = '0;
    for (int i = 0; i < NHARTS; i++) begin
      if (halt_ev[i]   && (hart_hg[i] != '0)) hg_hart_hit[hart_hg[i]] = 1'b1;
      if (resume_ev[i] && (hart_rg[i] != '0)) rg_hart_hit[hart_rg[i]] = 1'b1;
    end
    for (int k = 0; k < NTRIG; k++) begin
      if (trig_ev[k] && (trig_hg[k] != '0)) hg_trig_hit[trig_hg[k]] = 1'b1;
      if (trig_ev[k] && (trig_rg[k] != '0)) rg_trig_hit[trig_rg[k]] = 1'b1;
    end
  end

  xtg_resume_hold #(.NGROUPS(NGROUPS)) u_hold (
    .clk(clk), .rst_n(rst_n), .hit(rg_hart_hit | rg_trig_hit), .busy(abs_busy), .fire(rg_fire)
  );

  always_comb begin
    for (int i = 0; i < NHARTS; i++) begin
      halt_next[i]   = (hart_hg[i] != '0) && (hg_hart_hit[hart_hg[i]] || hg_trig_hit[hart_hg[i]])
                       && !hart_halted[i];
      resume_next[i] = (hart_rg[i] != '0) && rg_fire[hart_rg[i]] && hart_halted[i];
    end
    for (int k = 0; k < NTRIG; k++) begin
      tout_next[k] = drive_mask[k] &&
                     (((trig_hg[k] != '0) && hg_hart_hit[trig_hg[k]]) ||
                      ((trig_rg[k] != '0) && rg_hart_hit[trig_rg[k]]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_halt_req   <= '0;
      grp_resume_req <= '0;
      halt_cause     <= '0;
      trig_out       <= '0;
    end else begin
      grp_halt_req   <= halt_next;
      grp_resume_req <= resume_next;
      halt_cause     <= (|halt_next) ? CAUSE_GROUP : 3'd0;
      trig_out       <= tout_next;
    end
  end
endmodule

// File: rtl/xtg_crosstrig_chk.sv
module xtg_crosstrig_chk #(
  parameter int NHARTS = 4,
  parameter int NTRIG  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NHARTS-1:0] hart_halted,
  input logic              abs_busy,
  input logic [NHARTS-1:0] grp_halt_req,
  input logic [NHARTS-1:0] grp_resume_req,
  input logic [2:0]        halt_cause,
  input logic [NTRIG-1:0]  trig_out
);
  import xtg_pkg::*;

  logic [NTRIG-1:0] may_drive;
  for (genvar k = 0; k < NTRIG; k++) begin : g_m
    assign may_drive[k] = trig_can_drive(k);
  end

  AST_HALT_SKIPS_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_halt_req & $past(hart_halted)) == '0);                       // R4
  AST_CAUSE_ONLY_WITH_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_cause != 3'd0) |-> ((|grp_halt_req) && (halt_cause == 3'd6))); // R4
  AST_RESUME_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_resume_req) |-> !$past(abs_busy));                          // R7
  AST_RESUME_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_resume_req & ~$past(hart_halted)) == '0);                    // R7
  AST_TRIG_DRIVE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_out & ~may_drive) == '0);                                   // R9
endmodule

bind xtg_crosstrig xtg_crosstrig_chk #(.NHARTS(NHARTS), .NTRIG(NTRIG)) u_chk (
  .clk(clk), .rst_n(rst_n), .hart_halted(hart_halted), .abs_busy(abs_busy),
  .grp_halt_req(grp_halt_req), .grp_resume_req(grp_resume_req),
  .halt_cause(halt_cause), .trig_out(trig_out)
);

// File: tb/xtg_crosstrig_bench.sv
module xtg_crosstrig_bench;
  localparam int NH = 4, NT = 16, NG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_trig = 0, cfg_resume = 0;
  logic [3:0] cfg_index = '0;
  logic [2:0] cfg_group = '0;
  logic [NH-1:0] hart_halted = '0, hart_running = '0;
  logic abs_busy = 0;
  logic [NT-1:0] trig_in = '0;
  logic [NH-1:0] grp_halt_req, grp_resume_req;
  logic [2:0] halt_cause;
  logic [NT-1:0] trig_out;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  xtg_crosstrig u_xtg_crosstrig (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_trig(cfg_trig), .cfg_resume(cfg_resume),
    .cfg_index(cfg_index), .cfg_group(cfg_group), .hart_halted(hart_halted),
    .hart_running(hart_running), .abs_busy(abs_busy), .trig_in(trig_in),
    .grp_halt_req(grp_halt_req), .grp_resume_req(grp_resume_req),
    .halt_cause(halt_cause), .trig_out(trig_out)
  );

  // Behavioural reference: group tables, previous levels, pending resume flags.
  int mhg[NH], mrg[NH], thg[NT], trg[NT];
  bit ph[NH], pr[NH], pt[NT], pend[NG];
  logic [NH-1:0] e_halt = '0, e_res = '0;
  logic [NT-1:0] e_tout = '0;
  logic [2:0] e_cause = '0;

  always @(posedge clk or negedge rst_n) begin : model
    bit hh[NG], ht[NG], rh[NG], rt[NG], fire[NG];
    if (!rst_n) begin
      foreach (mhg[i]) begin mhg[i] = 0; mrg[i] = 0; ph[i] = 0; pr[i] = 0; end
      foreach (thg[k]) begin thg[k] = 0; trg[k] = 0; pt[k] = 0; end
      foreach (pend[g]) pend[g] = 0;
      e_halt = '0; e_res = '0; e_tout = '0; e_cause = '0;
    end else begin
      foreach (hh[g]) begin hh[g] = 0; ht[g] = 0; rh[g] = 0; rt[g] = 0; end
      for (int i = 0; i < NH; i++) begin
        if (hart_halted[i] && !ph[i] && mhg[i] != 0) hh[mhg[i]] = 1;
        if (hart_running[i] && !pr[i] && mrg[i] != 0) rh[mrg[i]] = 1;
      end
      for (int k = 0; k < 12; k++) begin
        if (trig_in[k] && !pt[k]) begin
          if (thg[k] != 0) ht[thg[k]] = 1;
          if (trg[k] != 0) rt[trg[k]] = 1;
        end
      end
      for (int g = 0; g < NG; g++) begin
        fire[g] = (pend[g] || rh[g] || rt[g]) && !abs_busy;
        pend[g] = (pend[g] || rh[g] || rt[g]) && abs_busy;
      end
      for (int i = 0; i < NH; i++) begin
        e_halt[i] = (mhg[i] != 0) && (hh[mhg[i]] || ht[mhg[i]]) && !hart_halted[i];
        e_res[i]  = (mrg[i] != 0) && fire[mrg[i]] && hart_halted[i];
      end
      for (int k = 0; k < NT; k++) begin
        bit drv;
        drv = (k < 8) || (k >= 12);
        e_tout[k] = drv && ((thg[k] != 0 && hh[thg[k]]) || (trg[k] != 0 && rh[trg[k]]));
      end
      e_cause = (|e_halt) ? 3'd6 : 3'd0;
      if (cfg_we) begin
        int v;
        v = (cfg_group >= NG) ? 0 : int'(cfg_group);
        if (cfg_trig) begin
          if (cfg_resume) trg[cfg_index] = v; else thg[cfg_index] = v;
        end else if (cfg_index < NH) begin
          if (cfg_resume) mrg[cfg_index] = v; else mhg[cfg_index] = v;
        end
      end
      for (int i = 0; i < NH; i++) begin ph[i] = hart_halted[i]; pr[i] = hart_running[i]; end
      for (int k = 0; k < NT; k++) pt[k] = trig_in[k];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (grp_halt_req !== e_halt || grp_resume_req !== e_res ||
          trig_out !== e_tout || halt_cause !== e_cause) begin
        errors++;
        $display("FAIL %s model: halt %b/%b res %b/%b tout %h/%h cause %0d/%0d (actual/expected)",
                 cur_req, grp_halt_req, e_halt, grp_resume_req, e_res,
                 trig_out, e_tout, halt_cause, e_cause);
      end
    end
  end

  task automatic tick(int n = 1);
    for (int j = 0; j < n; j++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s directed: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit trg_sel, bit res_sel, int idx, int grp);
    cfg_we = 1; cfg_trig = trg_sel; cfg_resume = res_sel;
    cfg_index = 4'(idx); cfg_group = 3'(grp);
    tick();
    cfg_we = 0;
  endtask

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hart_running = '1;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", {grp_halt_req, grp_resume_req, halt_cause, trig_out}, '0);
    rst_n = 1;
    tick(2);
    check("R1", {grp_halt_req, grp_resume_req, halt_cause, trig_out}, '0);

    // R3: everything still in group 0
    cur_req = "R3";
    hart_halted[0] = 1; hart_running[0] = 0; trig_in[0] = 1;
    tick();
    check("R3", {grp_halt_req, trig_out}, '0);
    hart_halted[0] = 0; hart_running[0] = 1; trig_in[0] = 0;
    tick(2);

    // R2/R4: harts 0..2 halt group 1, hart1 clamp test later; hart 3 halt group 2
    cur_req = "R2";
    wr(0, 0, 0, 1); wr(0, 0, 1, 1); wr(0, 0, 2, 1); wr(0, 0, 3, 2);
    wr(1, 0, 0, 1); wr(1, 0, 12, 1); wr(1, 0, 9, 1);
    cur_req = "R10";
    check("R10", {grp_halt_req, grp_resume_req, trig_out}, '0);
    cur_req = "R4";
    hart_halted[0] = 1; hart_running[0] = 0;
    tick();
    check("R4", grp_halt_req, 4'b0110);
    check("R4", halt_cause, 3'd6);
    check("R5", trig_out, 16'h1001);
    tick();
    check("R4", {grp_halt_req, halt_cause}, '0);

    // R6: sense-only trigger 9 moved to halt group 2, hart 3 running
    cur_req = "R6";
    wr(1, 0, 9, 2);
    trig_in[9] = 1;
    tick();
    check("R6", grp_halt_req, 4'b1000);
    check("R6", trig_out, '0);
    trig_in[9] = 0;
    // R9: drive-only line 13 in group 2 is never sensed
    cur_req = "R9";
    wr(1, 0, 13, 2);
    trig_in[13] = 1;
    tick();
    check("R9", grp_halt_req, '0);
    trig_in[13] = 0;
    tick();

    // R2 clamp: hart1 halt group written as 5 -> becomes 0
    cur_req = "R2";
    wr(0, 0, 1, 5);
    hart_halted = 4'b0001; hart_running = 4'b1110;
    tick();
    hart_halted[2] = 1; hart_running[2] = 0;
    tick();
    check("R2", grp_halt_req, 4'b0000);
    tick();

    // R7: resume group 1 = harts 0,1,2; all halted; hart 2 turned halting
    cur_req = "R7";
    hart_halted = 4'b1111; hart_running = 4'b0000;
    tick();
    wr(0, 1, 0, 1); wr(0, 1, 1, 1); wr(0, 1, 2, 1);
    abs_busy = 1;
    hart_halted[0] = 0; hart_running[0] = 1;
    hart_halted[2] = 0;
    tick();
    check("R7", grp_resume_req, '0);
    tick(3);
    check("R7", grp_resume_req, '0);
    abs_busy = 0;
    tick();
    check("R7", grp_resume_req, 4'b0010);
    tick();
    check("R7", grp_resume_req, '0);

    // R8: sense-capable trigger 10 in resume group 3 with hart 3
    cur_req = "R8";
    wr(0, 1, 3, 3); wr(1, 1, 10, 3);
    trig_in[10] = 1;
    tick();
    check("R8", grp_resume_req, 4'b1000);
    trig_in[10] = 0;
    tick();

    // R10: moving a halted hart next to halted harts does nothing
    cur_req = "R10";
    hart_halted = 4'b1111; hart_running = '0;
    tick();
    wr(0, 0, 1, 1); wr(0, 1, 3, 1);
    tick();
    check("R10", {grp_halt_req, grp_resume_req, trig_out}, '0);

    // R1: reset returns everyone to group 0
    cur_req = "R1";
    rst_n = 0; tick(); rst_n = 1;
    hart_halted = '0; hart_running = '1;
    tick(2);
    hart_halted[0] = 1; hart_running[0] = 0;
    tick();
    check("R1", {grp_halt_req, trig_out}, '0);

    // Random mix against the model
    cur_req = "MIX";
    for (int c = 0; c < 3000; c++) begin
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_trig = $urandom_range(0, 1);
      cfg_resume = $urandom_range(0, 1);
      cfg_index = 4'($urandom_range(0, 15));
      cfg_group = 3'($urandom_range(0, 7));
      for (int i = 0; i < NH; i++) begin
        case ($urandom_range(0, 5))
          0: begin hart_halted[i] = 1; hart_running[i] = 0; end
          1: begin hart_halted[i] = 0; hart_running[i] = 1; end
          2: begin hart_halted[i] = 0; hart_running[i] = 0; end
          default: ;
        endcase
      end
      if ($urandom_range(0, 5) == 0) abs_busy = ~abs_busy;
      trig_in = 16'($urandom) & 16'($urandom);
      tick();
    end
    cfg_we = 0;
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule